// File: doc/BRIEF.md
# Sixteen-Function Arithmetic, Logic and Shift Unit

This block is a purely combinational datapath element that takes two operand words, a carry input and a four-bit function select, and returns one result word with four status flags. Four sub-units compute at the same time: an adder, a bitwise logic unit, a right shifter/rotator and a left shifter/rotator. The upper two select bits choose which sub-unit drives the result. The lower two select bits choose the operation inside that sub-unit.

The carry input does two jobs. It is the carry into the adder, so one select code gives two related arithmetic results. It is also the bit rotated in by the rotate-through-carry operations. The flags are meant to be captured by a status register outside this block. That register, the operand sources and the result destination are all outside the block.

Top module: `alsu_core`

## Requirements
- R1: With sel[3:2]=00 and cin=0, sel[1:0]=00,01,10,11 give F = A, A+B, A-B-1 and A-1 (all modulo 2^W).
- R2: With sel[3:2]=00 and cin=1, sel[1:0]=00,01,10,11 give F = A+1, A+B+1, A-B and A.
- R3: For arithmetic codes, c_out is the carry out of A + Y + cin. Y is 0, B, NOT B or all ones for sel[1:0]=00,01,10,11. v_out is 1 exactly when A and Y have the same sign bit and F has the other sign bit.
- R4: With sel[3:2]=01, sel[1:0]=00,01,10,11 give A AND B, A OR B, A XOR B and NOT A. c_out and v_out are 0.
- R5: With sel[3:2]=10, F is A shifted right by one. The bit entering the top is 0 for sel[1:0]=00, A[0] for 01, cin for 10, and A[W-1] for 11. c_out equals A[0].
- R6: With sel[3:2]=11, F is A shifted left by one. The bit entering the bottom is 0 for sel[1:0]=00, A[W-1] for 01, cin for 10, and 0 for 11. c_out equals A[W-1].
- R7: For shift codes, v_out is A[W-1] XOR A[W-2] when sel=1111 and 0 for every other shift code.
- R8: z_out is 1 exactly when F is zero, and s_out equals F[W-1], for every code.
- R9: B does not affect the result or flags of the unary codes: sel=0000, 0011, 0111 and all shift codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W (16) | First operand |
| b_in | input | W (16) | Second operand |
| sel | input | 4 | Function select: [3:2] picks the unit, [1:0] the operation |
| cin | input | 1 | Carry into the adder; bit fed in by rotate-through-carry |
| f_out | output | W (16) | Result |
| c_out | output | 1 | Carry flag |
| z_out | output | 1 | Zero flag |
| s_out | output | 1 | Sign flag |
| v_out | output | 1 | Overflow flag |

## Verification
The bench targets signed overflow at 0x7FFF+1 and 0x8000-1. A design that compares the wrong sign bits would miss one of these or raise V on a plain borrow. It checks that subtraction with no borrow sets the carry, which a design that inverts the carry sense would clear. It checks that the rotate-through-carry operations take in cin and not a stale or constant bit, and that arithmetic shift left raises V only when the top two bits differ. A sweep over every code with assorted operands, including B changed under unary codes, catches a swapped sub-unit select or a stray B dependence.

// File: rtl/alsu_core.sv
module alsu_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [3:0]   sel,
  input  logic         cin,
  output logic [W-1:0] f_out,
  output logic         c_out,
  output logic         z_out,
  output logic         s_out,
  output logic         v_out
);
  localparam int MSB = W - 1;

  logic [W-1:0] y_op;
  logic [W:0]   sum;
  logic         add_v;
  logic [W-1:0] log_res;
  logic         r_fill, l_fill;
  logic [W-1:0] r_res, l_res;
  logic         l_v;

  always_comb begin
    case (sel[1:0])
      2'b00:   y_op = '0;
      2'b01:   y_op = b_in;
      2'b10:   y_op = ~b_in;
      default: y_op = '1;
    endcase
  end

  assign sum   = {1'b0, a_in} + {1'b0, y_op} + {{W{1'b0}}, cin};
  assign add_v = (a_in[MSB] == y_op[MSB]) && (sum[MSB] != a_in[MSB]);

  always_comb begin
    case (sel[1:0])
      2'b00:   log_res = a_in & b_in;
      2'b01:   log_res = a_in | b_in;
      2'b10:   log_res = a_in ^ b_in;
      default: log_res = ~a_in;
    endcase
  end

  always_comb begin
    case (sel[1:0])
      2'b00:   r_fill = 1'b0;
      2'b01:   r_fill = a_in[0];
      2'b10:   r_fill = cin;
      default: r_fill = a_in[MSB];
    endcase
    case (sel[1:0])
      2'b01:   l_fill = a_in[MSB];
      2'b10:   l_fill = cin;
      default: l_fill = 1'b0;
    endcase
  end

  assign r_res = {r_fill, a_in[MSB:1]};
  assign l_res = {a_in[MSB-1:0], l_fill};
  assign l_v   = (sel[1:0] == 2'b11) && (a_in[MSB] ^ a_in[MSB-1]);

  always_comb begin
    case (sel[3:2])
      2'b00: begin f_out = sum[MSB:0]; c_out = sum[W];     v_out = add_v; end
      2'b01: begin f_out = log_res;    c_out = 1'b0;       v_out = 1'b0;  end
      2'b10: begin f_out = r_res;      c_out = a_in[0];    v_out = 1'b0;  end
      default: begin f_out = l_res;    c_out = a_in[MSB];  v_out = l_v;   end
    endcase
  end

  assign z_out = ~|f_out;
  assign s_out = f_out[MSB];

  always_comb begin
    // R2
    if (sel == 4'b0011 && cin)
      pass_thru_chk: assert (f_out == a_in && c_out) else $error("pass-through code wrong");
    // R4
    if (sel[3:2] == 2'b01)
      logic_flags_chk: assert (!c_out && !v_out) else $error("logic flags not clear");
    // R5
    if (sel[3:2] == 2'b10)
      rshift_carry_chk: assert (c_out == a_in[0]) else $error("right shift carry wrong");
    // R6
    if (sel[3:2] == 2'b11)
      lshift_carry_chk: assert (c_out == a_in[MSB]) else $error("left shift carry wrong");
    // R7
    if (sel[3] && sel != 4'b1111)
      shift_overflow_chk: assert (!v_out) else $error("overflow on plain shift");
    // R8
    if (z_out)
      zero_sign_chk: assert (!s_out) else $error("zero result marked negative");
  end
endmodule

// File: tb/test_alsu_core.sv
module test_alsu_core;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, f;
  logic [3:0]   sel;
  logic         cin, c, z, s, v;
  int checks = 0, fails = 0;
  bit done = 0;

  alsu_core #(.W(W)) i_alsu_core (
    .a_in(a), .b_in(b), .sel(sel), .cin(cin),
    .f_out(f), .c_out(c), .z_out(z), .s_out(s), .v_out(v)
  );

  // expected {c, v, f} from the requirements
  function automatic logic [W+1:0] model(input logic [3:0] op, input logic ci,
                                          input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] t;
    logic [W-1:0] r, yy;
    logic cc, vv;
    cc = 0; vv = 0; r = '0;
    case (op[3:2])
      2'b00: begin
        yy = (op[1:0] == 0) ? '0 : (op[1:0] == 1) ? y : (op[1:0] == 2) ? ~y : '1;
        t = x + yy + ci;
        r = t[W-1:0]; cc = t[W];
        vv = (x[W-1] == yy[W-1]) && (r[W-1] != x[W-1]);
      end
      2'b01: r = (op[1:0] == 0) ? (x & y) : (op[1:0] == 1) ? (x | y) :
                 (op[1:0] == 2) ? (x ^ y) : ~x;
      2'b10: begin
        r = x >> 1; cc = x[0];
        if (op[1:0] == 1) r[W-1] = x[0];
        if (op[1:0] == 2) r[W-1] = ci;
        if (op[1:0] == 3) r[W-1] = x[W-1];
      end
      default: begin
        r = x << 1; cc = x[W-1];
        if (op[1:0] == 1) r[0] = x[W-1];
        if (op[1:0] == 2) r[0] = ci;
        if (op[1:0] == 3) vv = x[W-1] ^ x[W-2];
      end
    endcase
    return {cc, vv, r};
  endfunction

  task automatic apply(input logic [3:0] op, input logic ci, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    sel = op; cin = ci; a = x; b = y;
    #2;
  endtask

  task automatic expect_out(input string req, input logic [W-1:0] ef, input logic ec, input logic ev);
    logic ez, es;
    ez = (ef == 0); es = ef[W-1];
    checks++;
    if (f !== ef || c !== ec || v !== ev || z !== ez || s !== es) begin
      fails++;
      $display("FAIL %s sel=%b cin=%b a=%h b=%h: got f=%h c=%b v=%b z=%b s=%b, expected f=%h c=%b v=%b z=%b s=%b",
               req, sel, cin, a, b, f, c, v, z, s, ef, ec, ev, ez, es);
    end
  endtask

  task automatic run_model(input string req, input logic [3:0] op, input logic ci,
                           input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W+1:0] e;
    e = model(op, ci, x, y);
    apply(op, ci, x, y);
    expect_out(req, e[W-1:0], e[W+1], e[W]);
  endtask

  task automatic t_idle;
    apply(4'b0000, 0, '0, '0);
    expect_out("R8 idle zero", 16'h0000, 0, 0);
  endtask

  task automatic t_arith;
    apply(4'b0001, 0, 16'h1234, 16'h0F0F); expect_out("R1 add", 16'h2143, 0, 0);
    apply(4'b0011, 0, 16'h0000, 16'h5555); expect_out("R1 dec wrap", 16'hFFFF, 0, 0);
    apply(4'b0010, 0, 16'h0009, 16'h0003); expect_out("R1 sub-1", 16'h0005, 1, 0);
    apply(4'b0000, 1, 16'h7FFF, 16'h0000); expect_out("R3 inc overflow", 16'h8000, 0, 1);
    apply(4'b0010, 1, 16'h0005, 16'h0007); expect_out("R2 sub borrow", 16'hFFFE, 0, 0);
    apply(4'b0010, 1, 16'h8000, 16'h0001); expect_out("R3 sub overflow", 16'h7FFF, 1, 1);
    apply(4'b0001, 1, 16'hFFFF, 16'h0000); expect_out("R2 add+1 carry zero", 16'h0000, 1, 0);
    apply(4'b0011, 1, 16'hA5A5, 16'h1234); expect_out("R2 pass", 16'hA5A5, 1, 0);
  endtask

  task automatic t_logic;
    apply(4'b0100, 1, 16'hF0F0, 16'hFF00); expect_out("R4 and", 16'hF000, 0, 0);
    apply(4'b0101, 0, 16'hF0F0, 16'h0F00); expect_out("R4 or", 16'hFFF0, 0, 0);
    apply(4'b0110, 0, 16'hAAAA, 16'hAAAA); expect_out("R4 xor zero", 16'h0000, 0, 0);
    apply(4'b0111, 1, 16'h00FF, 16'h1234); expect_out("R4 not", 16'hFF00, 0, 0);
  endtask

  task automatic t_shifts;
    apply(4'b1000, 1, 16'h8001, 16'h0); expect_out("R5 shr", 16'h4000, 1, 0);
    apply(4'b1001, 0, 16'h0003, 16'h0); expect_out("R5 ror", 16'h8001, 1, 0);
    apply(4'b1010, 1, 16'h0002, 16'h0); expect_out("R5 rorc cin", 16'h8001, 0, 0);
    apply(4'b1011, 0, 16'h8004, 16'h0); expect_out("R5 asr", 16'hC002, 0, 0);
    apply(4'b1100, 1, 16'h8001, 16'h0); expect_out("R6 shl", 16'h0002, 1, 0);
    apply(4'b1101, 0, 16'hC000, 16'h0); expect_out("R6 rol", 16'h8001, 1, 0);
    apply(4'b1110, 1, 16'h4000, 16'h0); expect_out("R6 rolc cin", 16'h8001, 0, 0);
    apply(4'b1111, 0, 16'h4000, 16'h0); expect_out("R7 asl overflow", 16'h8000, 0, 1);
    apply(4'b1111, 0, 16'hC000, 16'h0); expect_out("R7 asl no overflow", 16'h8000, 1, 0);
    apply(4'b1100, 0, 16'h4000, 16'h0); expect_out("R7 shl no V", 16'h8000, 0, 0);
  endtask

  task automatic t_b_ignored;
    logic [3:0] ops [8] = '{4'b0000, 4'b0011, 4'b0111, 4'b1000, 4'b1010, 4'b1011, 4'b1101, 4'b1111};
    for (int i = 0; i < 8; i++) begin
      run_model("R9 b ignored (b=0)", ops[i], 1'(i), 16'h6B3C, 16'h0000);
      run_model("R9 b ignored (b=ffff)", ops[i], 1'(i), 16'h6B3C, 16'hFFFF);
    end
  endtask

  task automatic t_sweep;
    logic [W-1:0] x = 16'hACE1, y = 16'h1D2B;
    for (int n = 0; n < 40; n++) begin
      for (int op = 0; op < 16; op++) begin
        for (int ci = 0; ci < 2; ci++)
          run_model("R1-sweep R3 R5 R6 R8", 4'(op), 1'(ci), x, y);
      end
      x = {x[W-2:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
      y = {y[W-2:0], y[15] ^ y[14] ^ y[12] ^ y[3]};
      if (n == 5) x = 16'h8000;
      if (n == 6) y = 16'h7FFF;
    end
  endtask

  initial begin
    sel = 0; cin = 0; a = 0; b = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_idle;
    t_arith;
    t_logic;
    t_shifts;
    t_b_ignored;
    t_sweep;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule